// File: doc/BRIEF.md
# Battery-Backed Key Store Controller

A 32-bit memory-mapped register block that keeps a secret of eight key words plus one auxiliary ninth word and presents the key in parallel to a downstream cipher engine. Software can change the key words only after it unlocks program mode with a fixed magic word. That unlock wipes the key first, and program mode then stays on until power-on reset. A software erase command also exists. A status flag records whether the store has been wiped since the last nonzero key write.

An integrity check compares a checksum written by software with a checksum computed outside the block over the key words. The result lands in two status bits. One interrupt line is driven from a pending/mask pair, and the mask is changed only through separate enable and disable registers. A strap input makes the auxiliary word write-only. With the strap set, that word is erased along with the key, reads as zero, counts toward the wiped flag and can never be locked.

The functional reset restores control and status state. It leaves the key words, the auxiliary word, the program-mode bit and the lock untouched. Those last two return to zero only on power-on reset.

Top module: `key_vault_ctrl`

## Requirements
- R1: Only word-aligned byte addresses that map a register are decoded, at word indexes 0 status, 1 erase control, 2 unlock, 3 checksum, 4..11 key words, 12 auxiliary word, 13 error enable, 14 pending, 15 mask, 16 enable, 17 disable and 19 lock. Any other or misaligned address reads as zero and its writes change nothing.
- R2: Read data appears on `rdata_o` in the cycle after `re_i`, and is zero in any cycle that follows one without `re_i`.
- R3: Writing exactly 0x757BDF0D to the unlock register erases the key and sets status bit 0 (program mode), which holds until power-on reset. Any other value has no effect.
- R4: Key words 0..7 take writes only while program mode is set, and otherwise keep their value. They always read as zero, and their contents appear on `key_o` with word n at bits 32n+31:32n.
- R5: Writing 1 to bit 0 of the erase control register starts an erase. The register always reads zero, so each later write of 1 starts a new erase.
- R6: An erase clears key words 0..7. It clears the auxiliary word only when `wo_strap_i` is high. It sets status bit 4 (wiped).
- R7: An accepted nonzero write to a key word clears status bit 4. An accepted nonzero write to the auxiliary word clears it only when `wo_strap_i` is high. Zero writes leave the flag unchanged.
- R8: The auxiliary word takes writes only while program mode is set and the lock is clear. It reads as zero while `wo_strap_i` is high and as its stored value otherwise.
- R9: Lock bit 0 can be set by writing 1 and never cleared by software. While `wo_strap_i` is high it reads zero and cannot be set.
- R10: In program mode, a checksum write sets status bit 8 (check done) and sets status bit 9 when the value equals `crc_calc_i`. Outside program mode it has no effect. The checksum register reads zero.
- R11: Pending bit 0 is set by `bus_err_i` and cleared by writing 1 to it. The mask reads back but ignores direct writes. Writing 1 to the enable register clears the mask bit and writing 1 to the disable register sets it. `irq_o` is high while a pending bit is set with its mask bit clear.
- R12: `rst_ni` clears status bits 4, 8 and 9, the pending, mask and error-enable bits, and keeps the key, the auxiliary word, program mode and the lock. `por_ni` also clears program mode and the lock, and likewise keeps the key and the auxiliary word.
- R13: Bit 0 of the error-enable register is read/write, drives `err_en_o`, and its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Functional reset, active low, asynchronous |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| wo_strap_i | input | 1 | Auxiliary word write-only strap |
| we_i | input | 1 | Register write enable |
| re_i | input | 1 | Register read enable |
| addr_i | input | 7 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| crc_calc_i | input | 32 | Checksum computed over key words 0..7 |
| bus_err_i | input | 1 | Bus error event, sets pending bit 0 |
| key_o | output | 256 | Key words 0..7, packed |
| err_en_o | output | 1 | Error response enable |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions watch several rules on every cycle. Program mode and the lock must be sticky. Key words must stay frozen outside program mode when no erase is running. Every erase must leave the key zero with the wiped flag set. A locked auxiliary word must hold its value. The checksum status must stay unchanged outside program mode. An unmasked pending event must raise the interrupt, and an idle cycle must return zero read data. Other behaviour can be shown only by the bench's scenarios. These are the ignored unmapped and misaligned writes, the exact status encodings, and the different outcomes with and without the strap. They also include the split between functional and power-on reset, and the retention of key values across both resets.

// File: rtl/kv_pkg.sv
package kv_pkg;
  localparam logic [31:0] UNLOCK_MAGIC = 32'h757B_DF0D;

  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_CTRL   = 1;
  localparam int unsigned IDX_UNLOCK = 2;
  localparam int unsigned IDX_CRC    = 3;
  localparam int unsigned IDX_KEY0   = 4;
  localparam int unsigned IDX_ERREN  = 13;
  localparam int unsigned IDX_ISR    = 14;
  localparam int unsigned IDX_IMR    = 15;
  localparam int unsigned IDX_IER    = 16;
  localparam int unsigned IDX_IDR    = 17;
  localparam int unsigned IDX_LOCK   = 19;

  localparam int unsigned ST_PGM  = 0;
  localparam int unsigned ST_WIPE = 4;
  localparam int unsigned ST_DONE = 8;
  localparam int unsigned ST_PASS = 9;

  typedef struct packed {
    logic ctrl;
    logic unlock;
    logic crc;
    logic aux;
    logic erren;
    logic isr;
    logic ier;
    logic idr;
    logic lock;
  } wsel_t;
endpackage

// File: rtl/kv_dec.sv
module kv_dec
  import kv_pkg::*;
#(
  parameter int AW      = 7,
  parameter int NUM_KEY = 8
) (
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  output logic               aligned_o,
  output logic [AW-3:0]      idx_o,
  output wsel_t              wr_o,
  output logic [NUM_KEY-1:0] key_we_o
);
  localparam int unsigned AUX_IDX = IDX_KEY0 + NUM_KEY;

  int unsigned widx;
  logic        wen;

  assign aligned_o = (addr_i[1:0] == 2'b00);
  assign idx_o     = addr_i[AW-1:2];
  assign widx      = int'(idx_o);
  assign wen       = we_i && aligned_o;

  always_comb begin
    wr_o        = '0;
    wr_o.ctrl   = wen && (widx == IDX_CTRL);
    wr_o.unlock = wen && (widx == IDX_UNLOCK);
    wr_o.crc    = wen && (widx == IDX_CRC);
    wr_o.aux    = wen && (widx == AUX_IDX);
    wr_o.erren  = wen && (widx == IDX_ERREN);
    wr_o.isr    = wen && (widx == IDX_ISR);
    wr_o.ier    = wen && (widx == IDX_IER);
    wr_o.idr    = wen && (widx == IDX_IDR);
    wr_o.lock   = wen && (widx == IDX_LOCK);
  end

  for (genvar g = 0; g < NUM_KEY; g++) begin : g_kwe
    assign key_we_o[g] = wen && (widx == IDX_KEY0 + g);
  end
endmodule

// File: rtl/kv_key_bank.sv
module kv_key_bank #(
  parameter int DW      = 32,
  parameter int NUM_KEY = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pgm_i,
  input  logic                  lock_i,
  input  logic                  strap_i,
  input  logic                  zero_i,
  input  logic [NUM_KEY-1:0]    key_we_i,
  input  logic                  aux_we_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [NUM_KEY*DW-1:0] key_o,
  output logic [DW-1:0]         aux_o,
  output logic                  wiped_o
);
  logic [DW-1:0] key_q [NUM_KEY];
  logic [DW-1:0] aux_q;
  logic          aux_ok, key_ok, nz_hit, wiped_q;

  assign aux_ok = aux_we_i && pgm_i && !lock_i;
  assign key_ok = (|key_we_i) && pgm_i;
  assign nz_hit = (wdata_i != '0) && (key_ok || (aux_ok && strap_i));

  // key storage is retained across both resets
  for (genvar g = 0; g < NUM_KEY; g++) begin : g_key
    always_ff @(posedge clk_i) begin
      if (zero_i)                      key_q[g] <= '0;
      else if (key_we_i[g] && pgm_i)   key_q[g] <= wdata_i;
    end
    assign key_o[g*DW +: DW] = key_q[g];

    AST_KEY_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pgm_i && !zero_i) |=> $stable(key_q[g])); // R4
    AST_KEY_ERASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      zero_i |=> (key_q[g] == '0)); // R6
  end

  always_ff @(posedge clk_i) begin
    if (zero_i && strap_i) aux_q <= '0;
    else if (aux_ok)       aux_q <= wdata_i;
  end
  assign aux_o = aux_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wiped_q <= 1'b0;
    else if (zero_i) wiped_q <= 1'b1;
    else if (nz_hit) wiped_q <= 1'b0;
  end
  assign wiped_o = wiped_q;

  AST_WIPE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |=> wiped_q); // R6
  AST_AUX_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(aux_q)); // R8
endmodule

// File: rtl/kv_irq.sv
module kv_irq #(
  parameter int NIRQ = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NIRQ-1:0] set_i,
  input  logic            isr_we_i,
  input  logic            ier_we_i,
  input  logic            idr_we_i,
  input  logic [NIRQ-1:0] wdata_i,
  output logic [NIRQ-1:0] isr_o,
  output logic [NIRQ-1:0] imr_o,
  output logic            irq_o
);
  logic [NIRQ-1:0] isr_q, imr_q, clr;

  assign clr = isr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      imr_q <= '0;
    end else begin
      isr_q <= (isr_q & ~clr) | set_i;  // new event beats clear
      if (ier_we_i)      imr_q <= imr_q & ~wdata_i;
      else if (idr_we_i) imr_q <= imr_q | wdata_i;
    end
  end

  assign isr_o = isr_q;
  assign imr_o = imr_q;
  assign irq_o = |(isr_q & ~imr_q);

  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(set_i & ~imr_q)) && !idr_we_i) |=> irq_o); // R11
  AST_IDR_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idr_we_i && wdata_i[0]) |=> imr_q[0]); // R11
endmodule

// File: rtl/key_vault_ctrl.sv
module key_vault_ctrl
  import kv_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = 7,
  parameter int NUM_KEY = 8,
  parameter int NIRQ    = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  por_ni,
  input  logic                  wo_strap_i,
  input  logic                  we_i,
  input  logic                  re_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  input  logic [DW-1:0]         crc_calc_i,
  input  logic                  bus_err_i,
  output logic [NUM_KEY*DW-1:0] key_o,
  output logic                  err_en_o,
  output logic                  irq_o
);
  localparam int unsigned AUX_IDX = IDX_KEY0 + NUM_KEY;

  logic               rst_all_n;
  logic               aligned;
  logic [AW-3:0]      idx;
  wsel_t              wr;
  logic [NUM_KEY-1:0] key_we;
  logic               pgm_q, lock_q, lock_eff, err_en_q;
  logic               done_q, pass_q, wiped, zero_req;
  logic [DW-1:0]      aux, status_w, rd_mux, rdata_q;
  logic [NIRQ-1:0]    isr, imr;

  assign rst_all_n = rst_ni & por_ni;

  kv_dec #(.AW(AW), .NUM_KEY(NUM_KEY)) u_dec (
    .we_i     (we_i),
    .addr_i   (addr_i),
    .aligned_o(aligned),
    .idx_o    (idx),
    .wr_o     (wr),
    .key_we_o (key_we)
  );

  assign zero_req = (wr.ctrl && wdata_i[0]) ||
                    (wr.unlock && (wdata_i == UNLOCK_MAGIC));
  assign lock_eff = lock_q && !wo_strap_i;

  // survives functional reset, cleared only at power-on
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      pgm_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (wr.unlock && (wdata_i == UNLOCK_MAGIC)) pgm_q <= 1'b1;
      if (wo_strap_i)                   lock_q <= 1'b0;
      else if (wr.lock && wdata_i[0])   lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_all_n) begin
    if (!rst_all_n) begin
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
      err_en_q <= 1'b0;
    end else begin
      if (wr.crc && pgm_q) begin
        done_q <= 1'b1;
        pass_q <= (wdata_i == crc_calc_i);
      end
      if (wr.erren) err_en_q <= wdata_i[0];
    end
  end
  assign err_en_o = err_en_q;

  kv_key_bank #(.DW(DW), .NUM_KEY(NUM_KEY)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_all_n),
    .pgm_i   (pgm_q),
    .lock_i  (lock_eff),
    .strap_i (wo_strap_i),
    .zero_i  (zero_req),
    .key_we_i(key_we),
    .aux_we_i(wr.aux),
    .wdata_i (wdata_i),
    .key_o   (key_o),
    .aux_o   (aux),
    .wiped_o (wiped)
  );

  kv_irq #(.NIRQ(NIRQ)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_all_n),
    .set_i   ({{(NIRQ-1){1'b0}}, bus_err_i}),
    .isr_we_i(wr.isr),
    .ier_we_i(wr.ier),
    .idr_we_i(wr.idr),
    .wdata_i (wdata_i[NIRQ-1:0]),
    .isr_o   (isr),
    .imr_o   (imr),
    .irq_o   (irq_o)
  );

  always_comb begin
    status_w          = '0;
    status_w[ST_PGM]  = pgm_q;
    status_w[ST_WIPE] = wiped;
    status_w[ST_DONE] = done_q;
    status_w[ST_PASS] = pass_q;
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (int'(idx))
        IDX_STATUS: rd_mux = status_w;
        AUX_IDX:    rd_mux = wo_strap_i ? '0 : aux;
        IDX_ERREN:  rd_mux[0] = err_en_q;
        IDX_ISR:    rd_mux[NIRQ-1:0] = isr;
        IDX_IMR:    rd_mux[NIRQ-1:0] = imr;
        IDX_LOCK:   rd_mux[0] = lock_eff;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_all_n) begin
    if (!rst_all_n) rdata_q <= '0;
    else            rdata_q <= re_i ? rd_mux : '0;
  end
  assign rdata_o = rdata_q;

  AST_PGM_STICKY: assert property (@(posedge clk_i) disable iff (!por_ni)
    pgm_q |=> pgm_q); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!por_ni)
    (lock_q && !wo_strap_i) |=> lock_q); // R9
  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    !re_i |=> (rdata_o == '0)); // R2
  AST_CRC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    !pgm_q |=> $stable({done_q, pass_q})); // R10
endmodule

// File: tb/key_vault_ctrl_tb.sv
module key_vault_ctrl_tb;
  localparam logic [31:0] MAGIC = 32'h757B_DF0D;
  localparam logic [31:0] CRCV  = 32'h5555_AAAA;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0, por_n = 1'b0, strap = 1'b0;
  logic         we = 1'b0, re = 1'b0, be = 1'b0;
  logic [6:0]   addr = '0;
  logic [31:0]  wdata = '0, crc = CRCV;
  logic [31:0]  rdata;
  logic [255:0] key;
  logic         err_en, irq;
  logic [31:0]  ek [8];
  int           n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  key_vault_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .wo_strap_i(strap),
    .we_i(we), .re_i(re), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .crc_calc_i(crc), .bus_err_i(be), .key_o(key), .err_en_o(err_en), .irq_o(irq)
  );

  function automatic logic [31:0] st(bit p, bit z, bit d, bit s);
    return {22'd0, s, d, 3'd0, z, 3'd0, p};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, logic [31:0] exp, string tag);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic chk_keys(string tag);
    for (int i = 0; i < 8; i++) chk(tag, key[i*32 +: 32], ek[i]);
  endtask

  task automatic pulse_err();
    @(negedge clk); be = 1'b1;
    @(negedge clk); be = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;

    // R1 R12: reset state and full address sweep (aux word has no reset)
    for (int a = 0; a < 128; a++)
      if (a != 'h30) rd(7'(a), 32'h0, "R1/R12 sweep");

    // R3: wrong value then magic
    wr(7'h08, 32'h1234_5678);
    rd(7'h00, 32'h0, "R3 non-magic");
    wr(7'h08, MAGIC);
    rd(7'h00, st(1, 1, 0, 0), "R3 unlock");
    @(negedge clk); chk("R2 idle read", rdata, 32'h0);
    for (int i = 0; i < 8; i++) ek[i] = '0;
    chk_keys("R6 unlock erase");

    // R7 R4: zero write keeps flag, key writes accepted and read as zero
    wr(7'h10, 32'h0);
    rd(7'h00, st(1, 1, 0, 0), "R7 zero write");
    for (int i = 0; i < 8; i++) begin
      ek[i] = 32'(i + 1) * 32'h0101_0101;
      wr(7'(16 + 4 * i), ek[i]);
      rd(7'(16 + 4 * i), 32'h0, "R4 key reads zero");
    end
    chk_keys("R4 key written");
    rd(7'h00, st(1, 0, 0, 0), "R7 nonzero clears");

    // R8: aux word read back
    wr(7'h30, 32'hCAFE_0008);
    rd(7'h30, 32'hCAFE_0008, "R8 aux readback");

    // R1: unmapped and misaligned writes do nothing
    wr(7'h48, 32'hFFFF_FFFF);
    for (int a = 'h50; a < 128; a += 4) wr(7'(a), 32'hFFFF_FFFF);
    wr(7'h11, 32'hFFFF_FFFF);
    wr(7'h31, 32'hFFFF_FFFF);
    wr(7'h05, 32'h1);
    wr(7'h09, MAGIC);
    wr(7'h4D, 32'h1);
    rd(7'h00, st(1, 0, 0, 0), "R1 status untouched");
    chk_keys("R1 keys untouched");
    rd(7'h30, 32'hCAFE_0008, "R1 aux untouched");
    rd(7'h4C, 32'h0, "R1 lock untouched");

    // R10: checksum check
    wr(7'h0C, 32'h0000_1234);
    rd(7'h00, st(1, 0, 1, 0), "R10 mismatch");
    wr(7'h0C, CRCV);
    rd(7'h00, st(1, 0, 1, 1), "R10 match");
    rd(7'h0C, 32'h0, "R10 reads zero");

    // R6 R5: erase command, aux kept without strap
    wr(7'h04, 32'h1);
    rd(7'h00, st(1, 1, 1, 1), "R6 erase flag");
    for (int i = 0; i < 8; i++) ek[i] = '0;
    chk_keys("R6 erase keys");
    rd(7'h30, 32'hCAFE_0008, "R6 aux kept");
    rd(7'h04, 32'h0, "R5 self clear");
    wr(7'h10, 32'h7);
    rd(7'h00, st(1, 0, 1, 1), "R7 key clears flag");
    wr(7'h04, 32'h1);
    rd(7'h00, st(1, 1, 1, 1), "R5 second erase");
    chk_keys("R5 second erase keys");

    // R7 R8: aux write without strap leaves flag
    wr(7'h30, 32'h0000_BEEF);
    rd(7'h30, 32'h0000_BEEF, "R8 aux write");
    rd(7'h00, st(1, 1, 1, 1), "R7 aux no strap");

    // R9 R8: lock
    wr(7'h4C, 32'h1);
    rd(7'h4C, 32'h1, "R9 lock set");
    wr(7'h4C, 32'h0);
    rd(7'h4C, 32'h1, "R9 lock sticky");
    wr(7'h30, 32'h1);
    rd(7'h30, 32'h0000_BEEF, "R8 locked aux");

    // R11: interrupt
    chk("R11 irq idle", 32'(irq), 32'h0);
    pulse_err();
    chk("R11 irq raised", 32'(irq), 32'h1);
    rd(7'h38, 32'h1, "R11 pending");
    wr(7'h44, 32'h1);
    chk("R11 masked", 32'(irq), 32'h0);
    rd(7'h3C, 32'h1, "R11 mask set");
    wr(7'h3C, 32'h0);
    rd(7'h3C, 32'h1, "R11 mask read-only");
    wr(7'h40, 32'h1);
    chk("R11 unmasked", 32'(irq), 32'h1);
    rd(7'h3C, 32'h0, "R11 mask cleared");
    wr(7'h38, 32'h1);
    chk("R11 w1c", 32'(irq), 32'h0);
    rd(7'h38, 32'h0, "R11 pending cleared");
    pulse_err();

    // R13: error enable
    wr(7'h34, 32'hFFFF_FFFF);
    chk("R13 err_en", 32'(err_en), 32'h1);
    rd(7'h34, 32'h1, "R13 readback");

    // R4: load final key values
    for (int i = 0; i < 8; i++) begin
      ek[i] = 32'(i + 1) * 32'h1111_1111;
      wr(7'(16 + 4 * i), ek[i]);
    end
    chk_keys("R4 reload");

    // R12: functional reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(7'h00, st(1, 0, 0, 0), "R12 rst status");
    rd(7'h4C, 32'h1, "R12 rst lock kept");
    rd(7'h38, 32'h0, "R12 rst pending");
    chk("R12 rst err_en", 32'(err_en), 32'h0);
    chk("R12 rst irq", 32'(irq), 32'h0);
    chk_keys("R12 rst keys kept");
    rd(7'h30, 32'h0000_BEEF, "R12 rst aux kept");

    // R12 R4 R8 R10: power-on reset, then writes outside program mode
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    rd(7'h00, 32'h0, "R12 por status");
    rd(7'h4C, 32'h0, "R12 por lock");
    chk_keys("R12 por keys kept");
    wr(7'h10, 32'hDEAD_DEAD);
    chk_keys("R4 dropped write");
    wr(7'h30, 32'h0000_1234);
    rd(7'h30, 32'h0000_BEEF, "R8 aux dropped");
    wr(7'h0C, CRCV);
    rd(7'h00, 32'h0, "R10 outside program");

    // strap set: R8 R9 R3 R7 R6
    @(negedge clk); strap = 1'b1;
    rd(7'h30, 32'h0, "R8 strap reads zero");
    wr(7'h4C, 32'h1);
    rd(7'h4C, 32'h0, "R9 strap lock");
    wr(7'h08, MAGIC);
    rd(7'h00, st(1, 1, 0, 0), "R3 unlock strap");
    for (int i = 0; i < 8; i++) ek[i] = '0;
    chk_keys("R6 strap erase");
    wr(7'h30, 32'h0000_0077);
    rd(7'h00, st(1, 0, 0, 0), "R7 aux strap clears");
    wr(7'h04, 32'h1);
    rd(7'h00, st(1, 1, 0, 0), "R6 strap erase flag");
    @(negedge clk); strap = 1'b0;
    rd(7'h30, 32'h0, "R6 aux erased");
    rd(7'h4C, 32'h0, "R9 lock still clear");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule